// File: doc/BRIEF.md
# Single-Tag Ring Issue Column

This block is one column of an issue window built as a ring of identical columns. It holds a small window of instructions, one bank of the physical register file and a two-function ALU (add or subtract). An instruction may enter the window waiting on at most one operand, and that operand can only come from the column immediately to its left. Each entry therefore stores a single wakeup tag, and that tag is compared only against the left neighbour's result broadcast.

When the left neighbour's result tag matches an entry's pending tag, the entry latches the bypassed value from the ring link and becomes ready. Each cycle the oldest ready entry issues. Its non-pending operands are read from the local bank at issue time. The ALU result is written back through the bank's only write port and is broadcast, with its tag, to the right-hand neighbour. Instructions whose operands are all available on entry are ready as soon as they are inserted.

Top module: `ring_issue_column`

## Requirements
- R1: After reset, `full`, `iss_valid` and `res_valid` are 0, and every bank register reads as 0.
- R2: An instruction inserted with `ins_pend`=0 and driven in cycle n appears on `iss_*` and `res_*` in cycle n+2 when no older entry is ready.
- R3: `ins_sub`=0 selects a+b and `ins_sub`=1 selects a-b, both modulo 2^16. Operand a is `iss_opa`, operand b is `iss_opb`.
- R4: A result is written to the bank register indexed by the low 4 bits of its destination tag. Later instructions that name that index read the new value.
- R5: An entry with `ins_pend`=1 does not issue while the left broadcast carries a different tag or has `left_valid`=0.
- R6: The pending operand is operand b when `ins_pend_b`=1 and operand a otherwise. When `left_valid`=1 and `left_tag` equals the pending tag in cycle w, the entry takes `left_data` as that operand and can issue with outputs in cycle w+2.
- R7: At most one instruction issues per cycle. Among ready entries, the one inserted earliest issues first.
- R8: `full` is 1 when the window holds 8 entries. An insertion while `full`=1 is dropped and never issues.
- R9: `res_tag` equals the issued destination tag `iss_dst`, and `res_valid` rises together with `iss_valid`.
- R10: A left broadcast that matches a pending tag in the same cycle that entry is inserted wakes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_sub | input | 1 | 1 = subtract, 0 = add |
| ins_dst | input | 16 | Destination tag; low 4 bits index the local bank |
| ins_src_a | input | 16 | Operand a: bank index (low bits) or pending tag |
| ins_src_b | input | 16 | Operand b: bank index (low bits) or pending tag |
| ins_pend | input | 1 | One operand waits on a left-neighbour result |
| ins_pend_b | input | 1 | The waiting operand is b (else a) |
| left_valid | input | 1 | Left neighbour broadcasts a result |
| left_tag | input | 16 | Left neighbour result tag |
| left_data | input | 16 | Left neighbour ALU result (ring bypass) |
| full | output | 1 | Window holds its maximum number of entries |
| iss_valid | output | 1 | An instruction issued |
| iss_sub | output | 1 | Operation of the issued instruction |
| iss_dst | output | 16 | Destination tag of the issued instruction |
| iss_opa | output | 16 | Operand a value used |
| iss_opb | output | 16 | Operand b value used |
| res_valid | output | 1 | Result broadcast to the right neighbour |
| res_tag | output | 16 | Result tag to the right neighbour |
| res_data | output | 16 | ALU result |

## Verification
The hardest case to reach is contention: several ready entries must exist in the same cycle so that oldest-first selection actually decides something. Inserted instructions without a pending operand drain one per cycle, so they never compete. The bench parks several entries on one shared pending tag and then wakes them all with a single broadcast. It reaches the full window the same way: it parks eight waiting entries, then offers a ninth instruction that would otherwise issue immediately.

// File: rtl/ring_iq_pkg.sv
package ring_iq_pkg;
    localparam int VAL_W = 16;
    localparam int TAG_W = 16;

    typedef logic [VAL_W-1:0] val_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic vld;
        logic sub;
        tag_t dst;
        tag_t src_a;
        tag_t src_b;
        logic pend;     // one operand still waiting on the left neighbour
        logic on_b;     // waiting/bypassed operand is b
        logic byp;      // operand value latched from the ring link
        val_t byp_val;
    } iq_entry_t;

    function automatic iq_entry_t apply_wake(iq_entry_t e, logic wv, tag_t wt, val_t wd);
        iq_entry_t r;
        r = e;
        if (e.vld && e.pend && wv && ((e.on_b ? e.src_b : e.src_a) == wt)) begin
            r.pend    = 1'b0;
            r.byp     = 1'b1;
            r.byp_val = wd;
        end
        return r;
    endfunction
endpackage

// File: rtl/ring_iq_pick.sv
module ring_iq_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  ready,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g]  = ready[g] & ~seen[g];
        assign seen[g+1] = seen[g] | ready[g];
    end

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
    // R7
    grant_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> ready[idx] && ((ready & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/ring_iq_bank.sv
module ring_iq_bank
    import ring_iq_pkg::*;
#(
    parameter int REGS = 16,
    parameter int BW   = $clog2(REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [BW-1:0] waddr,
    input  val_t          wdata,
    input  logic [BW-1:0] raddr_a,
    input  logic [BW-1:0] raddr_b,
    output val_t          rdata_a,
    output val_t          rdata_b
);
    val_t mem [REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/ring_iq_alu.sv
module ring_iq_alu
    import ring_iq_pkg::*;
(
    input  logic sub,
    input  val_t a,
    input  val_t b,
    output val_t y
);
    assign y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/ring_issue_column.sv
module ring_issue_column
    import ring_iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int REGS  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ins_valid,
    input  logic        ins_sub,
    input  logic [15:0] ins_dst,
    input  logic [15:0] ins_src_a,
    input  logic [15:0] ins_src_b,
    input  logic        ins_pend,
    input  logic        ins_pend_b,
    input  logic        left_valid,
    input  logic [15:0] left_tag,
    input  logic [15:0] left_data,
    output logic        full,
    output logic        iss_valid,
    output logic        iss_sub,
    output logic [15:0] iss_dst,
    output logic [15:0] iss_opa,
    output logic [15:0] iss_opb,
    output logic        res_valid,
    output logic [15:0] res_tag,
    output logic [15:0] res_data
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int BW = $clog2(REGS);

    iq_entry_t win_q [DEPTH];
    iq_entry_t upd   [DEPTH];
    iq_entry_t win_d [DEPTH];
    logic [CW-1:0] count_q, count_d, slot;

    logic [DEPTH-1:0] ready, grant;
    logic             fire;
    logic [IW-1:0]    sel_idx;
    iq_entry_t        ne;
    logic             accept;
    val_t             rd_a, rd_b, opa, opb, alu_y;

    assign full   = (count_q == CW'(DEPTH));
    assign accept = ins_valid & ~full;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ready
        assign ready[g] = win_q[g].vld & ~win_q[g].pend;
    end

    ring_iq_pick #(.N(DEPTH), .IW(IW)) u_pick (
        .clk(clk), .rst(rst), .ready(ready), .grant(grant), .any(fire), .idx(sel_idx)
    );

    ring_iq_bank #(.REGS(REGS), .BW(BW)) u_bank (
        .clk(clk), .rst(rst),
        .we(fire), .waddr(win_q[sel_idx].dst[BW-1:0]), .wdata(alu_y),
        .raddr_a(win_q[sel_idx].src_a[BW-1:0]), .raddr_b(win_q[sel_idx].src_b[BW-1:0]),
        .rdata_a(rd_a), .rdata_b(rd_b)
    );

    // Ring bypass value overrides the bank read for the latched operand.
    assign opa = (win_q[sel_idx].byp && !win_q[sel_idx].on_b) ? win_q[sel_idx].byp_val : rd_a;
    assign opb = (win_q[sel_idx].byp &&  win_q[sel_idx].on_b) ? win_q[sel_idx].byp_val : rd_b;

    ring_iq_alu u_alu (.sub(win_q[sel_idx].sub), .a(opa), .b(opb), .y(alu_y));

    always_comb begin
        ne         = '0;
        ne.vld     = 1'b1;
        ne.sub     = ins_sub;
        ne.dst     = ins_dst;
        ne.src_a   = ins_src_a;
        ne.src_b   = ins_src_b;
        ne.pend    = ins_pend;
        ne.on_b    = ins_pend_b;
        ne         = apply_wake(ne, left_valid, left_tag, left_data);

        for (int i = 0; i < DEPTH; i++)
            upd[i] = apply_wake(win_q[i], left_valid, left_tag, left_data);

        // Collapse the issued slot so index order stays age order.
        for (int i = 0; i < DEPTH - 1; i++)
            win_d[i] = (fire && (i >= int'(sel_idx))) ? upd[i+1] : upd[i];
        win_d[DEPTH-1] = fire ? '0 : upd[DEPTH-1];

        slot = count_q - CW'(fire);
        if (accept) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == slot) win_d[i] = ne;
        end
        count_d = slot + CW'(accept);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) win_q[i] <= '0;
            count_q   <= '0;
            iss_valid <= 1'b0;
            iss_sub   <= 1'b0;
            iss_dst   <= '0;
            iss_opa   <= '0;
            iss_opb   <= '0;
            res_valid <= 1'b0;
            res_tag   <= '0;
            res_data  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) win_q[i] <= win_d[i];
            count_q   <= count_d;
            iss_valid <= fire;
            res_valid <= fire;
            if (fire) begin
                iss_sub  <= win_q[sel_idx].sub;
                iss_dst  <= win_q[sel_idx].dst;
                iss_opa  <= opa;
                iss_opb  <= opb;
                res_tag  <= win_q[sel_idx].dst;
                res_data <= alu_y;
            end
        end
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst) count_q <= CW'(DEPTH));
    // R8
    full_no_grow_chk: assert property (@(posedge clk) disable iff (rst) full |=> count_q <= $past(count_q));
    // R5
    issue_not_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> win_q[sel_idx].vld && !win_q[sel_idx].pend);
    // R3
    result_arith_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (iss_sub ? (VAL_W'(res_data + iss_opb) == iss_opa)
                               : (res_data == VAL_W'(iss_opa + iss_opb))));
    // R9
    result_tag_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> iss_valid && (res_tag == iss_dst));
endmodule

// File: tb/ring_issue_column_test.sv
module ring_issue_column_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        ins_valid, ins_sub, ins_pend, ins_pend_b;
    logic [15:0] ins_dst, ins_src_a, ins_src_b;
    logic        left_valid;
    logic [15:0] left_tag, left_data;
    logic        full, iss_valid, iss_sub, res_valid;
    logic [15:0] iss_dst, iss_opa, iss_opb, res_tag, res_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    ring_issue_column uut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_sub(ins_sub), .ins_dst(ins_dst),
        .ins_src_a(ins_src_a), .ins_src_b(ins_src_b),
        .ins_pend(ins_pend), .ins_pend_b(ins_pend_b),
        .left_valid(left_valid), .left_tag(left_tag), .left_data(left_data),
        .full(full), .iss_valid(iss_valid), .iss_sub(iss_sub), .iss_dst(iss_dst),
        .iss_opa(iss_opa), .iss_opb(iss_opb),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] vreg(input int k);
        return (k == 0) ? 16'h0 : (16'(k * 4099) ^ 16'h5a5a);
    endfunction

    task automatic idle();
        ins_valid = 0; ins_sub = 0; ins_pend = 0; ins_pend_b = 0;
        ins_dst = 0; ins_src_a = 0; ins_src_b = 0;
        left_valid = 0; left_tag = 0; left_data = 0;
    endtask

    task automatic put(input bit sub, input logic [15:0] dst, a, b, input bit pend, pb);
        ins_valid = 1; ins_sub = sub; ins_dst = dst;
        ins_src_a = a; ins_src_b = b; ins_pend = pend; ins_pend_b = pb;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    // wait for a result; returns the number of negedges since the drive
    task automatic wait_res(output int lat);
        lat = 1;
        while (!res_valid && lat < 12) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_op(input bit sub, input int a, input int b, input logic [15:0] dst,
                          input logic [15:0] exp, input string req);
        int lat;
        put(sub, dst, 16'(a), 16'(b), 0, 0);
        step();
        wait_res(lat);
        chk(lat == 2, {req, "/R2 latency"}, lat, 2);
        chk(res_data == exp, {req, "/R3 data"}, res_data, exp);
        chk(res_tag == dst && iss_dst == dst, "R9 tag", res_tag, dst);
        @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk(full == 0, "R1 full", full, 0);
        chk(iss_valid == 0 && res_valid == 0, "R1 valid", {iss_valid, res_valid}, 0);
        run_op(0, 7, 9, 16'h6000, 16'h0, "R1 bank zero");

        // R10: load bank k via same-cycle wakeup of an inserted waiting entry
        for (int k = 1; k < 16; k++) begin
            put(0, 16'(k), 16'h8000 | 16'(k), 16'h0, 1, 0);
            left_valid = 1; left_tag = 16'h8000 | 16'(k); left_data = vreg(k);
            step();
            wait_res(lat);
            chk(lat == 2, "R10 latency", lat, 2);
            chk(res_data == vreg(k), "R10 data", res_data, vreg(k));
            @(negedge clk);
        end

        // R3/R4 sweep over all operand pairs and both operations
        for (int a = 1; a < 16; a++)
            for (int b = 1; b < 16; b++)
                for (int s = 0; s < 2; s++)
                    run_op(s[0], a, b, 16'h5000,
                           s[0] ? 16'(vreg(a) - vreg(b)) : 16'(vreg(a) + vreg(b)), "R4 sweep");
        run_op(1, 0, 0, 16'h5000, 16'h0, "R3 clear");

        // R4: write idx 14 through a wide tag, read it back
        run_op(0, 1, 2, 16'h030E, 16'(vreg(1) + vreg(2)), "R4 write");
        run_op(0, 14, 0, 16'h040D, 16'(vreg(1) + vreg(2)), "R4 readback");

        // R5/R6: pending operand a
        put(0, 16'h010F, 16'hA001, 16'd3, 1, 0);
        step();
        for (int i = 0; i < 5; i++) begin
            left_valid = 1; left_tag = 16'hA002 + 16'(i); left_data = 16'hFFFF;
            step();
            chk(res_valid == 0, "R5 wrong tag", res_valid, 0);
        end
        left_valid = 0; left_tag = 16'hA001; left_data = 16'hFFFF;
        step();
        chk(res_valid == 0, "R5 invalid broadcast", res_valid, 0);
        left_valid = 1; left_tag = 16'hA001; left_data = 16'h1234;
        step();
        chk(res_valid == 0, "R6 early", res_valid, 0);
        @(negedge clk);
        chk(res_valid == 1, "R6 timing", res_valid, 1);
        chk(res_data == 16'(16'h1234 + vreg(3)), "R6 operand a", res_data, 16'(16'h1234 + vreg(3)));
        @(negedge clk);

        // R6: pending operand b with subtract
        put(1, 16'h020F, 16'd5, 16'hA100, 1, 1);
        step();
        left_valid = 1; left_tag = 16'hA100; left_data = 16'h0F0F;
        step();
        @(negedge clk);
        chk(res_valid == 1, "R6 timing b", res_valid, 1);
        chk(res_data == 16'(vreg(5) - 16'h0F0F), "R6 operand b", res_data, 16'(vreg(5) - 16'h0F0F));
        @(negedge clk);

        // R7: three entries wake together, oldest issues first, one per cycle
        for (int j = 1; j <= 3; j++) begin
            put(0, 16'(j * 256 + 15) | 16'h3000, 16'hB000, 16'(j), 1, 0);
            step();
        end
        left_valid = 1; left_tag = 16'hB000; left_data = 16'h0100;
        step();
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            chk(res_valid == 1, "R7 one per cycle", res_valid, 1);
            chk(res_tag == (16'(j * 256 + 15) | 16'h3000), "R7 oldest first", res_tag,
                16'(j * 256 + 15) | 16'h3000);
            chk(res_data == 16'(16'h0100 + vreg(j)), "R7 data", res_data, 16'(16'h0100 + vreg(j)));
        end
        @(negedge clk);

        // R8: fill with eight waiting entries, the ninth is dropped
        for (int j = 0; j < 8; j++) begin
            chk(full == 0, "R8 not full yet", full, 0);
            put(0, 16'h1000 | 16'(j * 256 + 15), 16'hC000, 16'h0, 1, 0);
            step();
        end
        chk(full == 1, "R8 full", full, 1);
        put(0, 16'h2F0F, 16'd1, 16'd2, 0, 0);
        step();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(res_valid == 0 && full == 1, "R8 dropped insert", {res_valid, full}, 2'b01);
        end
        left_valid = 1; left_tag = 16'hC000; left_data = 16'h0777;
        step();
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            chk(res_valid == 1 && res_tag == (16'h1000 | 16'(j * 256 + 15)), "R8 drain order",
                res_tag, 16'h1000 | 16'(j * 256 + 15));
            chk(res_data == 16'h0777, "R8 drain data", res_data, 16'h0777);
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(res_valid == 0, "R8 ninth never issues", res_valid, 0);
        end
        chk(full == 0, "R8 full clears", full, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule